// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Line Controller

This block turns pin transitions on several 16-bit GPIO ports into interrupt requests. It has sixteen interrupt lines, and line n watches pin n of whichever port its selector names. Because each line number is a multiplexer over ports, only one port can own line n at any time. Each line has its own rising-edge and falling-edge enable. A qualifying edge on an unmasked line sets that line's pending bit, and the bit stays set until software clears it.

The pending bits, gated by the mask, drive seven registered request outputs. Lines 0 to 4 each have a dedicated request. Lines 5 to 9 share one request, and lines 10 to 15 share another. An interrupt service routine behind a shared request reads the pending register to find which line fired. Pin inputs pass through a synchronizer. An edge is found by comparing each line's synchronized level with its value one cycle earlier, and a selector write suppresses detection for one cycle so that changing port does not create a false edge.

Top module: `extint_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0 (all selectors code 0, no trigger enabled, all lines masked, nothing pending) and all request outputs are low.
- R2: Selector registers sit at addresses 0 to 3. Line n uses bits [4*(n%4)+3 : 4*(n%4)] of the register at address n/4. A code p below NUM_PORTS connects line n to port_pins[p*16+n], and pin n of any other port has no effect on line n.
- R3: A selector code of NUM_PORTS or above connects the line to a constant 0, so that line never sees an edge.
- R4: When bit n of the rising-enable register (address 4) is set, a low-to-high transition on line n sets pending bit n.
- R5: When bit n of the falling-enable register (address 5) is set, a high-to-low transition on line n sets pending bit n. A rising transition on that line does nothing unless rising is also enabled.
- R6: With both enables set, every transition on the line sets its pending bit. With neither set, no transition does.
- R7: In the mask register (address 6), bit n = 1 unmasks line n. An edge on a masked line does not set its pending bit. A request is driven only by bits that are both pending and unmasked, so masking a pending line drops its request and leaves the bit pending.
- R8: The pending register (address 7) reads the pending bits. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: If a qualifying edge and a clear of the same bit happen in the same cycle, the pending bit stays set.
- R10: Writing a selector does not create an edge on the lines that register covers, even when the newly selected level differs from the old one. A real edge after the change is detected normally.
- R11: When line n's selector is written twice with different ports, only the port in the later write drives the line.
- R12: irq_line[k] is pending&mask of line k for k = 0 to 4. irq_mid is the OR of pending&mask over lines 5 to 9. irq_hi is the OR over lines 10 to 15. All are registered one cycle after the pending bits.
- R13: bus_rdata presents the register at bus_addr one cycle after the address is applied. Unused upper bits read 0, and data bits above the register's width are ignored on write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_pins | input | NUM_PORTS*16 | Asynchronous pin levels; port p occupies bits [16p+15:16p] |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_line | output | 5 | Dedicated requests for lines 0 to 4 |
| irq_mid | output | 1 | Shared request for lines 5 to 9 |
| irq_hi | output | 1 | Shared request for lines 10 to 15 |

## Verification
The bench sweeps every line against every port and toggles pin n of a neighbouring port as a decoy. A design with a wrong mux index or field offset would set the pending bit for the decoy, or for the wrong line. It times a pending-clear write into the exact cycle in which an edge is detected: a design where the clear wins would lose that interrupt. It switches a line between ports at different levels, and into an unused code, with both edges enabled. A design that does not suppress edge detection after a selector write would report a spurious interrupt. Mask tests confirm that a masked line neither sets its pending bit nor keeps its request alive, and that the shared requests merge exactly their own line ranges.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int NUM_LINES     = 16;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 3;
  localparam int SEL_W         = 4;
  localparam int SEL_PER_REG   = 4;
  localparam int NUM_SEL_REGS  = NUM_LINES / SEL_PER_REG;
  localparam int SEL_FIELD_W   = SEL_W * SEL_PER_REG;
  localparam int DED_LINES     = 5;   // lines with a private request
  localparam int MID_LAST      = 9;   // last line of the middle group

  typedef enum logic [ADDR_W-1:0] {
    A_SEL0 = 3'd0,
    A_SEL1 = 3'd1,
    A_SEL2 = 3'd2,
    A_SEL3 = 3'd3,
    A_RISE = 3'd4,
    A_FALL = 3'd5,
    A_MASK = 3'd6,
    A_PEND = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [NUM_LINES-1:0]       pend,
  output logic [NUM_LINES*SEL_W-1:0] sel,
  output logic [NUM_LINES-1:0]       rise_en,
  output logic [NUM_LINES-1:0]       fall_en,
  output logic [NUM_LINES-1:0]       mask,
  output logic [NUM_LINES-1:0]       reload,
  output logic [NUM_LINES-1:0]       clr,
  output logic [DATA_W-1:0]          bus_rdata
);
  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= '0;
      rise_en <= '0;
      fall_en <= '0;
      mask    <= '0;
      reload  <= '0;
    end else begin
      for (int w = 0; w < NUM_SEL_REGS; w++) begin
        if (bus_wr && bus_addr == ADDR_W'(w))
          sel[w*SEL_FIELD_W +: SEL_FIELD_W] <= bus_wdata[SEL_FIELD_W-1:0];
        reload[w*SEL_PER_REG +: SEL_PER_REG] <=
          {SEL_PER_REG{bus_wr && bus_addr == ADDR_W'(w)}};
      end
      if (bus_wr && bus_addr == A_RISE) rise_en <= bus_wdata[NUM_LINES-1:0];
      if (bus_wr && bus_addr == A_FALL) fall_en <= bus_wdata[NUM_LINES-1:0];
      if (bus_wr && bus_addr == A_MASK) mask    <= bus_wdata[NUM_LINES-1:0];
    end
  end

  assign clr = (bus_wr && bus_addr == A_PEND) ? bus_wdata[NUM_LINES-1:0] : '0;

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NUM_SEL_REGS; w++)
      if (bus_addr == ADDR_W'(w))
        rd_next[SEL_FIELD_W-1:0] = sel[w*SEL_FIELD_W +: SEL_FIELD_W];
    case (bus_addr)
      A_RISE:  rd_next[NUM_LINES-1:0] = rise_en;
      A_FALL:  rd_next[NUM_LINES-1:0] = fall_en;
      A_MASK:  rd_next[NUM_LINES-1:0] = mask;
      A_PEND:  rd_next[NUM_LINES-1:0] = pend;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PORTS*NUM_LINES-1:0] pins_s,
  input  logic [NUM_LINES*SEL_W-1:0]     sel,
  input  logic [NUM_LINES-1:0]           rise_en,
  input  logic [NUM_LINES-1:0]           fall_en,
  input  logic [NUM_LINES-1:0]           mask,
  input  logic [NUM_LINES-1:0]           reload,
  input  logic [NUM_LINES-1:0]           clr,
  output logic [NUM_LINES-1:0]           hit,
  output logic [NUM_LINES-1:0]           pend
);
  logic [NUM_LINES-1:0] lvl;
  logic [NUM_LINES-1:0] prev;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [SEL_W-1:0] code;
    logic             lvl_n;
    assign code = sel[n*SEL_W +: SEL_W];
    always_comb begin
      lvl_n = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++)
        if (code == SEL_W'(p)) lvl_n = pins_s[p*NUM_LINES + n];
    end
    assign lvl[n] = lvl_n;
  end

  // a selector write makes prev stale for one cycle; that cycle is ignored
  assign hit = ~reload & ((rise_en & lvl & ~prev) | (fall_en & ~lvl & prev));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      pend <= '0;
    end else begin
      prev <= lvl;
      pend <= (pend & ~clr) | (hit & mask);
    end
  end
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [DED_LINES-1:0]           irq_line,
  output logic                           irq_mid,
  output logic                           irq_hi
);
  localparam int PIN_W = NUM_PORTS * NUM_LINES;

  logic [PIN_W-1:0]           pins_s;
  logic [NUM_LINES*SEL_W-1:0] sel;
  logic [NUM_LINES-1:0]       rise_en, fall_en, mask, reload, clr, hit, pend_q;

  extint_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(port_pins), .q(pins_s)
  );

  extint_regs u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pend(pend_q), .sel(sel), .rise_en(rise_en),
    .fall_en(fall_en), .mask(mask), .reload(reload), .clr(clr),
    .bus_rdata(bus_rdata)
  );

  extint_detect #(.NUM_PORTS(NUM_PORTS)) u_detect (
    .clk(clk), .rst(rst), .pins_s(pins_s), .sel(sel), .rise_en(rise_en),
    .fall_en(fall_en), .mask(mask), .reload(reload), .clr(clr),
    .hit(hit), .pend(pend_q)
  );

  logic [NUM_LINES-1:0] active;
  assign active = pend_q & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_line <= '0;
      irq_mid  <= 1'b0;
      irq_hi   <= 1'b0;
    end else begin
      irq_line <= active[DED_LINES-1:0];
      irq_mid  <= |active[MID_LAST:DED_LINES];
      irq_hi   <= |active[NUM_LINES-1:MID_LAST+1];
    end
  end
endmodule

// File: rtl/extint_ctrl_chk.sv
module extint_ctrl_chk
  import extint_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] mask,
  input logic [NUM_LINES-1:0] hit,
  input logic [NUM_LINES-1:0] clr,
  input logic [NUM_LINES-1:0] reload,
  input logic [DED_LINES-1:0] irq_line,
  input logic                 irq_mid,
  input logic                 irq_hi
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pend == '0 && irq_line == '0 && !irq_mid && !irq_hi)); // R1

  AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(mask)) == '0)); // R7

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(clr & ~hit)) == '0)); // R8

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(hit & mask) & ~pend) == '0)); // R9

  AST_SEL_NO_FALSE_EDGE: assert property (@(posedge clk) disable iff (rst)
    (|reload) |=> ((pend & ~$past(pend) & $past(reload)) == '0)); // R10

  AST_GROUP_MID: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_mid == $past(|(pend[MID_LAST:DED_LINES] & mask[MID_LAST:DED_LINES])))); // R12

  AST_GROUP_HI: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_hi == $past(|(pend[NUM_LINES-1:MID_LAST+1] & mask[NUM_LINES-1:MID_LAST+1])))); // R12
endmodule

bind extint_ctrl extint_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .pend(pend_q), .mask(mask), .hit(hit), .clr(clr),
  .reload(reload), .irq_line(irq_line), .irq_mid(irq_mid), .irq_hi(irq_hi)
);

// File: tb/tb_extint_ctrl.sv
module tb_extint_ctrl;
  localparam int NP = 4;
  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP*NL-1:0] port_pins = '0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [4:0]    irq_line;
  logic          irq_mid, irq_hi;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] sel_sh [4];

  always #5 clk = ~clk;

  extint_ctrl dut (
    .clk(clk), .rst(rst), .port_pins(port_pins), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_line(irq_line), .irq_mid(irq_mid), .irq_hi(irq_hi)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic setpin(input int idx, input logic v);
    @(negedge clk); port_pins[idx] = v;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic set_sel(input int line, input int code);
    sel_sh[line/4][4*(line%4) +: 4] = 4'(code);
    wr(3'(line/4), {16'h0, sel_sh[line/4]});
  endtask

  function automatic logic [6:0] exp_irq(input logic [15:0] p, input logic [15:0] m);
    logic [15:0] a;
    a = p & m;
    return {|a[15:10], |a[9:5], a[4:0]};
  endfunction

  function automatic logic [6:0] act_irq();
    return {irq_hi, irq_mid, irq_line};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 4; i++) sel_sh[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(act_irq() == 7'h0, "R1 irq", {25'h0, act_irq()}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk(d == 32'h0, "R1 reg", d, 32'h0);
    end

    // R13: readback and ignored upper bits
    wr(3'd2, 32'hFFFF_3A51);
    rd(3'd2, d); chk(d == 32'h0000_3A51, "R13 sel", d, 32'h0000_3A51);
    wr(3'd4, 32'h1234_ABCD);
    rd(3'd4, d); chk(d == 32'h0000_ABCD, "R13 rise", d, 32'h0000_ABCD);
    wr(3'd2, 32'h0);

    // R2 R4 R12: sweep every line against every port
    wr(3'd4, 32'hFFFF); wr(3'd5, 32'h0); wr(3'd6, 32'hFFFF);
    for (int n = 0; n < NL; n++) begin
      for (int p = 0; p < NP; p++) begin
        int q;
        q = (p + 1) % NP;
        set_sel(n, p);
        wr(3'd7, 32'hFFFF);
        setpin(q*NL + n, 1'b1); settle();
        rd(3'd7, d); chk(d == 32'h0, "R2 decoy port", d, 32'h0);
        setpin(q*NL + n, 1'b0); settle();
        setpin(p*NL + n, 1'b1); settle();
        chk(act_irq() == exp_irq(16'(1 << n), 16'hFFFF), "R12 grouping",
            {25'h0, act_irq()}, {25'h0, exp_irq(16'(1 << n), 16'hFFFF)});
        rd(3'd7, d); chk(d == 32'(1 << n), "R4 rising", d, 32'(1 << n));
        setpin(p*NL + n, 1'b0); settle();
        rd(3'd7, d); chk(d == 32'(1 << n), "R5 no fall when disabled", d, 32'(1 << n));
        wr(3'd7, 32'hFFFF);
      end
    end
    for (int w = 0; w < 4; w++) begin sel_sh[w] = '0; wr(3'(w), 32'h0); end

    // R5: falling only on line 3, port 0
    wr(3'd4, 32'h0); wr(3'd5, 32'h0008); wr(3'd7, 32'hFFFF);
    setpin(3, 1'b1); settle();
    rd(3'd7, d); chk(d == 32'h0, "R5 rise ignored", d, 32'h0);
    setpin(3, 1'b0); settle();
    rd(3'd7, d); chk(d == 32'h0008, "R5 falling", d, 32'h0008);
    wr(3'd7, 32'hFFFF);

    // R6: both edges on line 12 via port 1, then neither
    set_sel(12, 1);
    wr(3'd4, 32'h1000); wr(3'd5, 32'h1000); wr(3'd7, 32'hFFFF);
    setpin(NL + 12, 1'b1); settle();
    rd(3'd7, d); chk(d == 32'h1000, "R6 both rise", d, 32'h1000);
    chk(irq_hi == 1'b1, "R12 hi group", {31'h0, irq_hi}, 32'h1);
    wr(3'd7, 32'h1000); settle();
    rd(3'd7, d); chk(d == 32'h0, "R8 clear", d, 32'h0);
    setpin(NL + 12, 1'b0); settle();
    rd(3'd7, d); chk(d == 32'h1000, "R6 both fall", d, 32'h1000);
    wr(3'd7, 32'hFFFF);
    wr(3'd4, 32'h0); wr(3'd5, 32'h0);
    setpin(NL + 12, 1'b1); settle(); setpin(NL + 12, 1'b0); settle();
    rd(3'd7, d); chk(d == 32'h0, "R6 neither", d, 32'h0);
    set_sel(12, 0);

    // R7 R8: mask gating and write-one-to-clear
    wr(3'd4, 32'hFFFF); wr(3'd6, 32'hFFFB); wr(3'd7, 32'hFFFF);
    setpin(0, 1'b1); setpin(2, 1'b1); setpin(6, 1'b1); settle();
    rd(3'd7, d); chk(d == 32'h0041, "R7 masked no set", d, 32'h0041);
    chk(act_irq() == exp_irq(16'h0041, 16'hFFFB), "R7 irq",
        {25'h0, act_irq()}, {25'h0, exp_irq(16'h0041, 16'hFFFB)});
    wr(3'd6, 32'h0001); settle();
    chk(act_irq() == exp_irq(16'h0041, 16'h0001), "R7 mask drops request",
        {25'h0, act_irq()}, {25'h0, exp_irq(16'h0041, 16'h0001)});
    rd(3'd7, d); chk(d == 32'h0041, "R7 pending kept", d, 32'h0041);
    wr(3'd7, 32'h0); settle();
    rd(3'd7, d); chk(d == 32'h0041, "R8 write zero", d, 32'h0041);
    wr(3'd7, 32'h0001); settle();
    rd(3'd7, d); chk(d == 32'h0040, "R8 clear one", d, 32'h0040);
    wr(3'd6, 32'hFFFF); wr(3'd4, 32'h0);
    setpin(0, 1'b0); setpin(2, 1'b0); setpin(6, 1'b0); settle();
    wr(3'd7, 32'hFFFF);

    // R9: clear lands in the cycle the edge is detected
    wr(3'd4, 32'h0002);
    @(negedge clk); port_pins[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = 32'h0002;
    @(negedge clk); bus_wr = 1'b0;
    settle();
    rd(3'd7, d); chk(d == 32'h0002, "R9 edge beats clear", d, 32'h0002);
    wr(3'd7, 32'h0002); settle();
    rd(3'd7, d); chk(d == 32'h0, "R8 later clear", d, 32'h0);
    setpin(1, 1'b0); wr(3'd4, 32'h0); settle();

    // R10 R3: port switch without false edges, unused code reads 0
    wr(3'd4, 32'h0020); wr(3'd5, 32'h0020);
    setpin(5, 1'b1); settle();
    wr(3'd7, 32'hFFFF); settle();
    set_sel(5, 1); settle();
    rd(3'd7, d); chk(d == 32'h0, "R10 switch high to low", d, 32'h0);
    setpin(NL + 5, 1'b1); settle();
    rd(3'd7, d); chk(d == 32'h0020, "R10 real edge after switch", d, 32'h0020);
    wr(3'd7, 32'hFFFF);
    set_sel(5, 9); settle();
    rd(3'd7, d); chk(d == 32'h0, "R10 switch to unused code", d, 32'h0);
    for (int p = 0; p < NP; p++) begin
      setpin(p*NL + 5, 1'b0); settle(); setpin(p*NL + 5, 1'b1); settle();
    end
    rd(3'd7, d); chk(d == 32'h0, "R3 unused code constant", d, 32'h0);
    set_sel(5, 0); settle();
    rd(3'd7, d); chk(d == 32'h0, "R10 switch low to high", d, 32'h0);
    for (int p = 0; p < NP; p++) setpin(p*NL + 5, 1'b0);
    settle(); wr(3'd7, 32'hFFFF); wr(3'd5, 32'h0);

    // R11: last written selector owns the line
    wr(3'd4, 32'h0008);
    set_sel(3, 1); set_sel(3, 2); settle();
    setpin(NL + 3, 1'b1); settle();
    rd(3'd7, d); chk(d == 32'h0, "R11 earlier port ignored", d, 32'h0);
    setpin(2*NL + 3, 1'b1); settle();
    rd(3'd7, d); chk(d == 32'h0008, "R11 later port active", d, 32'h0008);
    chk(irq_line == 5'h08, "R12 dedicated line", {27'h0, irq_line}, 32'h08);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule